// File: doc/BRIEF.md
# Synonym-Resolving Second-Level Cache Controller

This controller manages the tag side of a physically-addressed, direct-mapped second-level cache. It sits under a small virtually-indexed first-level cache that uses write-through. Each first-level miss or write-through arrives carrying a virtual address. The controller translates that address through a small internal translation table, which is loaded over a write port, and then looks up the physical tag.

Every second-level block records:
- a tag;
- a dirty bit;
- a child pointer, made of a valid bit and the superset bits of the first-level index where the block currently lives.

The child pointer acts as a reverse translation. When a block is requested under a new virtual index, the controller uses the pointer to invalidate the old first-level copy. It then fills the block at the new index. A physical block therefore never has more than one first-level copy, and that copy sits under the virtual address used most recently. Victim replacement also keeps inclusion: a victim's child is invalidated before the victim is dropped.

Memory traffic, first-level commands and requests all use valid/ready handshakes. The controller serves one request at a time.

Top module: `l2_synonym_ctrl`

## Requirements
- R1: A request address is split into a 4-bit virtual page number `req_va[7:4]` and a 4-bit block offset `req_va[3:0]`. The page number is matched against four table entries, each written through `tlb_we`/`tlb_sel` with a page number and a 4-bit physical page. When several entries match, the lowest-numbered entry wins. The physical block address is {physical page, offset}.
- R2: When no valid table entry matches, the request ends with `done_valid` and `done_fault`=1. No first-level command and no memory operation is issued, and the cache state does not change.
- R3: The second-level set is {ppn[1:0], offset} and the tag is ppn[3:2]. A read that misses issues a memory read (`mem_write`=0) at the physical block address. It then issues a fill (`cmd_fill`=1) at first-level index {va[5:4], offset}, and then ends with `done_valid` and `done_fault`=0.
- R4: A read that hits a block whose child is valid at a different first-level index first issues an invalidate (`cmd_fill`=0) at {child superset, offset}. It then issues a fill at the new index, and the child pointer moves to the new index.
- R5: A read that hits a block with no valid child issues only the fill. It causes no memory traffic.
- R6: A write request (`req_write`=1) never fills the first level. A write hit sets the dirty bit without memory traffic, and first invalidates a child held at a different index. A write miss allocates the block as dirty after the memory read.
- R7: On a miss into a valid set, the controller first invalidates the victim's child, if it has one. It then writes the victim back (`mem_write`=1) at {victim tag, set}, if the victim is dirty. Only after that does it issue the memory read for the new block.
- R8: A fill at a first-level index clears the child pointer of any other block that pointed to that index. A later read of such a block issues no invalidate.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after the `done_valid` pulse. An offered command or memory operation keeps its valid signal and its fields stable until ready is seen.
- R10: A valid child pointer always belongs to a valid block, and no two blocks point at the same first-level index.
- R11: After reset, all blocks and table entries are invalid, `req_ready` is 1, and `cmd_valid`, `mem_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tlb_we | input | 1 | Write one translation entry |
| tlb_sel | input | 2 | Entry number to write |
| tlb_vpn | input | 4 | Virtual page number of the entry |
| tlb_ppn | input | 4 | Physical page of the entry |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting |
| req_va | input | 8 | Virtual block address of the request |
| req_write | input | 1 | 1 = write-through, 0 = read miss |
| cmd_valid | output | 1 | First-level command offered |
| cmd_ready | input | 1 | First level takes the command |
| cmd_fill | output | 1 | 1 = fill, 0 = invalidate |
| cmd_idx | output | 6 | First-level index {superset, offset} |
| mem_valid | output | 1 | Memory operation offered |
| mem_ready | input | 1 | Memory takes the operation |
| mem_write | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 8 | Physical block address |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion was a translation fault |

## Verification
A single fill does two pointer updates in one cycle. It sets the requested block's pointer, and it clears the pointer of another block that shares the offset and the superset. The bench provokes this by bringing two different physical pages into the same first-level index one after the other. It then re-reads the first page and expects a plain fill with no invalidate. A reference model in the bench predicts every handshake, while the ready signals stall at random. Any difference in the order or the address of the commands shows up at the port where it is taken.

// File: rtl/l2_synonym_ctrl.sv
`timescale 1ns/1ps
module l2_synonym_ctrl #(
  parameter int VPN_W = 4,
  parameter int PPN_W = 4,
  parameter int OFF_W = 4,
  parameter int SS_W  = 2,
  parameter int SET_W = 2,
  parameter int TLB_N = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tlb_we,
  input  logic [$clog2(TLB_N)-1:0] tlb_sel,
  input  logic [VPN_W-1:0]       tlb_vpn,
  input  logic [PPN_W-1:0]       tlb_ppn,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W+OFF_W-1:0] req_va,
  input  logic                   req_write,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic                   cmd_fill,
  output logic [SS_W+OFF_W-1:0]  cmd_idx,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic                   mem_write,
  output logic [PPN_W+OFF_W-1:0] mem_addr,
  output logic                   done_valid,
  output logic                   done_fault
);
  localparam int IDX_W = SET_W + OFF_W;
  localparam int TAG_W = PPN_W - SET_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int L1_W  = SS_W + OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_INV, S_WB, S_RD, S_FILL, S_DONE} st_t;
  st_t state;

  logic [TLB_N-1:0]             tv;
  logic [TLB_N-1:0][VPN_W-1:0]  tvpn;
  logic [TLB_N-1:0][PPN_W-1:0]  tppn;

  logic [SETS-1:0]              lv, ld, lc;
  logic [SETS-1:0][TAG_W-1:0]   lt;
  logic [SETS-1:0][SS_W-1:0]    ls;

  logic             r_fault, r_wr, inv_syn;
  logic [PPN_W-1:0] r_ppn;
  logic [SS_W-1:0]  r_ss;
  logic [OFF_W-1:0] r_off;
  logic [L1_W-1:0]  inv_idx;

  logic             t_hit;
  logic [PPN_W-1:0] t_ppn;
  always_comb begin
    t_hit = 1'b0;
    t_ppn = '0;
    for (int i = TLB_N - 1; i >= 0; i--)
      if (tv[i] && tvpn[i] == req_va[OFF_W +: VPN_W]) begin
        t_hit = 1'b1;
        t_ppn = tppn[i];
      end
  end

  wire [IDX_W-1:0] idx  = {r_ppn[SET_W-1:0], r_off};
  wire [TAG_W-1:0] tag  = r_ppn[PPN_W-1:SET_W];
  wire             hit  = lv[idx] && lt[idx] == tag;
  wire [L1_W-1:0]  new1 = {r_ss, r_off};

  assign req_ready  = state == S_IDLE;
  assign cmd_valid  = state == S_INV || state == S_FILL;
  assign cmd_fill   = state == S_FILL;
  assign cmd_idx    = (state == S_FILL) ? new1 : inv_idx;
  assign mem_valid  = state == S_WB || state == S_RD;
  assign mem_write  = state == S_WB;
  assign mem_addr   = (state == S_WB) ? {lt[idx], idx} : {r_ppn, r_off};
  assign done_valid = state == S_DONE;
  assign done_fault = done_valid && r_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tv <= '0; tvpn <= '0; tppn <= '0;
      lv <= '0; ld <= '0; lc <= '0; lt <= '0; ls <= '0;
      r_fault <= 1'b0; r_wr <= 1'b0; inv_syn <= 1'b0;
      r_ppn <= '0; r_ss <= '0; r_off <= '0; inv_idx <= '0;
    end else begin
      if (tlb_we) begin
        tv[tlb_sel]   <= 1'b1;
        tvpn[tlb_sel] <= tlb_vpn;
        tppn[tlb_sel] <= tlb_ppn;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          r_fault <= !t_hit;
          r_ppn   <= t_ppn;
          r_ss    <= req_va[OFF_W +: SS_W];
          r_off   <= req_va[OFF_W-1:0];
          r_wr    <= req_write;
          state   <= S_LOOK;
        end
        S_LOOK: begin
          if (r_fault) state <= S_DONE;
          else if (hit) begin
            if (r_wr) ld[idx] <= 1'b1;
            if (lc[idx] && ls[idx] != r_ss) begin
              inv_idx <= {ls[idx], r_off};
              inv_syn <= 1'b1;
              state   <= S_INV;
            end else state <= r_wr ? S_DONE : S_FILL;
          end else if (lv[idx] && lc[idx]) begin
            inv_idx <= {ls[idx], r_off};
            inv_syn <= 1'b0;
            state   <= S_INV;
          end else state <= (lv[idx] && ld[idx]) ? S_WB : S_RD;
        end
        S_INV: if (cmd_ready) begin
          lc[idx] <= 1'b0;
          if (inv_syn) state <= r_wr ? S_DONE : S_FILL;
          else         state <= ld[idx] ? S_WB : S_RD;
        end
        S_WB: if (mem_ready) state <= S_RD;
        S_RD: if (mem_ready) begin
          lv[idx] <= 1'b1;
          lt[idx] <= tag;
          ld[idx] <= r_wr;
          lc[idx] <= 1'b0;
          state   <= r_wr ? S_DONE : S_FILL;
        end
        S_FILL: if (cmd_ready) begin
          for (int j = 0; j < (1 << SET_W); j++)
            if (lc[{j[SET_W-1:0], r_off}] && ls[{j[SET_W-1:0], r_off}] == r_ss)
              lc[{j[SET_W-1:0], r_off}] <= 1'b0;
          lc[idx] <= 1'b1;
          ls[idx] <= r_ss;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l2_synonym_ctrl_chk.sv
`timescale 1ns/1ps
module l2_synonym_ctrl_chk #(
  parameter int OFF_W = 4,
  parameter int SS_W  = 2,
  parameter int SET_W = 2,
  parameter int PPN_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic cmd_fill,
  input logic [SS_W+OFF_W-1:0] cmd_idx,
  input logic mem_valid,
  input logic mem_ready,
  input logic mem_write,
  input logic [PPN_W+OFF_W-1:0] mem_addr,
  input logic done_valid,
  input logic done_fault,
  input logic [(1<<(SET_W+OFF_W))-1:0] lv,
  input logic [(1<<(SET_W+OFF_W))-1:0] lc,
  input logic [(1<<(SET_W+OFF_W))-1:0][SS_W-1:0] ls
);
  localparam int WAYS = 1 << SET_W;
  localparam int OFFS = 1 << OFF_W;

  logic touched;
  always_ff @(posedge clk) begin
    if (!rst_n) touched <= 1'b0;
    else if (req_valid && req_ready) touched <= 1'b0;
    else if (cmd_valid || mem_valid) touched <= 1'b1;
  end

  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int o = 0; o < OFFS; o++)
      for (int a = 0; a < WAYS; a++)
        for (int b = a + 1; b < WAYS; b++)
          if (lc[a*OFFS+o] && lc[b*OFFS+o] && ls[a*OFFS+o] == ls[b*OFFS+o])
            clash = 1'b1;
  end

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_idx) && $stable(cmd_fill)));
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
  a_r2_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> !touched);
  a_r10_inclusion: assert property (@(posedge clk) disable iff (!rst_n)
    (lc & ~lv) == '0);
  a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !clash);
endmodule

bind l2_synonym_ctrl l2_synonym_ctrl_chk #(.OFF_W(OFF_W), .SS_W(SS_W), .SET_W(SET_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_fill(cmd_fill), .cmd_idx(cmd_idx),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .done_valid(done_valid), .done_fault(done_fault), .lv(lv), .lc(lc), .ls(ls));

// File: tb/tb_l2_synonym_ctrl.sv
`timescale 1ns/1ps
module tb_l2_synonym_ctrl;
  logic clk = 0, rst_n = 0;
  logic tlb_we = 0; logic [1:0] tlb_sel = 0; logic [3:0] tlb_vpn = 0, tlb_ppn = 0;
  logic req_valid = 0, req_write = 0; logic [7:0] req_va = 0;
  logic cmd_ready = 1, mem_ready = 1;
  logic req_ready, cmd_valid, cmd_fill, mem_valid, mem_write, done_valid, done_fault;
  logic [5:0] cmd_idx; logic [7:0] mem_addr;

  l2_synonym_ctrl dut (.clk(clk), .rst_n(rst_n), .tlb_we(tlb_we), .tlb_sel(tlb_sel),
    .tlb_vpn(tlb_vpn), .tlb_ppn(tlb_ppn), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_fill(cmd_fill), .cmd_idx(cmd_idx), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .done_valid(done_valid), .done_fault(done_fault));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  string cur_req = "R11";
  int exq[$];
  bit pending = 0, acc = 0, stall_on = 0;

  bit tv[4]; int tvp[4], tpp[4];
  bit mv[64], md[64], cv[64]; int mt[64], cs[64];

  // expected event codes: 0 inval, 1 fill, 2 write-back, 3 read, 4 done, 5 fault
  task automatic model(input int va, input bit wr);
    int vpn, off, ppn, ss, set, tg;
    vpn = va >> 4; off = va & 15; ppn = -1;
    for (int i = 3; i >= 0; i--) if (tv[i] && tvp[i] == vpn) ppn = tpp[i];
    if (ppn < 0) begin exq.push_back(5 << 8); return; end
    ss = vpn & 3; set = ((ppn & 3) << 4) | off; tg = ppn >> 2;
    if (mv[set] && mt[set] == tg) begin
      if (cv[set] && cs[set] != ss) begin exq.push_back((cs[set] << 4) | off); cv[set] = 0; end
      if (wr) md[set] = 1;
    end else begin
      if (mv[set] && cv[set]) begin exq.push_back((cs[set] << 4) | off); cv[set] = 0; end
      if (mv[set] && md[set]) exq.push_back((2 << 8) | (mt[set] << 6) | set);
      exq.push_back((3 << 8) | (ppn << 4) | off);
      mv[set] = 1; mt[set] = tg; md[set] = wr; cv[set] = 0;
    end
    if (!wr) begin
      exq.push_back((1 << 8) | (ss << 4) | off);
      for (int j = 0; j < 4; j++) if (cv[(j << 4) | off] && cs[(j << 4) | off] == ss) cv[(j << 4) | off] = 0;
      cv[set] = 1; cs[set] = ss;
    end
    exq.push_back(4 << 8);
  endtask

  task automatic compare(input int act);
    int exp;
    tests++;
    if (exq.size() == 0) begin
      fails++; $display("FAIL %s: unexpected event act=%h exp=none", cur_req, act);
    end else begin
      exp = exq.pop_front();
      if (exp != act) begin fails++; $display("FAIL %s: event act=%h exp=%h", cur_req, act, exp); end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pending && req_ready) begin
      tests++; fails++; $display("FAIL R9: req_ready act=1 exp=0 while busy");
    end
    if (cmd_valid && cmd_ready) compare(((cmd_fill ? 1 : 0) << 8) | cmd_idx);
    if (mem_valid && mem_ready) compare(((mem_write ? 2 : 3) << 8) | mem_addr);
    if (done_valid) begin compare((done_fault ? 5 : 4) << 8); pending = 0; end
    if (req_valid && req_ready) begin model(req_va, req_write); pending = 1; acc = 1; end
  end

  always @(posedge clk) begin
    #5;
    cmd_ready = stall_on ? ($urandom % 3 != 0) : 1'b1;
    mem_ready = stall_on ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic load(input int sel, input int vpn, input int ppn);
    @(posedge clk); #5;
    tlb_we = 1; tlb_sel = sel[1:0]; tlb_vpn = vpn[3:0]; tlb_ppn = ppn[3:0];
    tv[sel] = 1; tvp[sel] = vpn; tpp[sel] = ppn;
    @(posedge clk); #5; tlb_we = 0;
  endtask

  task automatic issue(input int va, input bit wr);
    @(posedge clk); #5;
    acc = 0; req_va = va[7:0]; req_write = wr; req_valid = 1;
    wait (acc);
    @(posedge clk); #5; req_valid = 0;
    wait (!pending);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++; $display("FAIL watchdog: act=hung exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    @(negedge clk);
    tests++;
    if (!(req_ready && !cmd_valid && !mem_valid && !done_valid)) begin
      fails++; $display("FAIL R11: reset outputs act=%b%b%b%b exp=1000", req_ready, cmd_valid, mem_valid, done_valid);
    end
    cur_req = "R11"; issue('h13, 0);            // empty table faults
    cur_req = "R2";  issue('h73, 0);
    load(0, 1, 5); load(1, 2, 5); load(2, 3, 9); load(3, 5, 6);
    cur_req = "R3";  issue('h13, 0);            // miss: read 0x53, fill 0x13
    cur_req = "R4";  issue('h23, 0);            // synonym: inv 0x13, fill 0x23
    cur_req = "R3";  issue('h53, 0);            // other set, same first-level index
    cur_req = "R6";  issue('h13, 1);            // write hit, synonym invalidate, dirty
    cur_req = "R7";  issue('h33, 0);            // dirty victim write-back
    cur_req = "R7";  issue('h13, 0);            // victim child invalidate first
    cur_req = "R8";  issue('h53, 0);            // pointer was displaced: plain fill
    cur_req = "R5";  issue('h53, 0);
    cur_req = "R2";  issue('h93, 1);
    cur_req = "R6";  issue('h2A, 1);            // write miss allocates dirty, no fill
    cur_req = "R7";  issue('h3A, 0);
    stall_on = 1;
    cur_req = "R10";
    for (int n = 0; n < 300; n++) begin
      int pick, vp;
      pick = $urandom % 5;
      vp = (pick == 0) ? 1 : (pick == 1) ? 2 : (pick == 2) ? 3 : (pick == 3) ? 5 : 7;
      issue((vp << 4) | ($urandom % 3), ($urandom % 4) == 0);
    end
    stall_on = 0;
    load(3, 1, 12);
    cur_req = "R1";  issue('h14, 0);            // entry 0 wins: read 0x54
    repeat (4) @(negedge clk);
    tests++;
    if (exq.size() != 0) begin fails++; $display("FAIL R9: leftover events act=%0d exp=0", exq.size()); end
    summary();
  end
endmodule